// File: doc/BRIEF.md
# Deduplicating Sharing-Pattern Table

This block holds the distinct P-bit sharer vectors used by a coherence directory. It keeps each distinct vector once and returns a short pointer for it. A client that needs a sharer vector inserts it and stores the returned pointer. When the client stops using that vector, it releases the pointer. A separate read port turns any pointer back into a vector. Entries that hold the same vector are shared, and a reference count on each entry frees the entry once no client holds its pointer.

The storage is a grid of rows and columns. An incoming vector is folded into one bit per cluster of cores, and the folded value selects the row, so vectors that differ only inside clusters land in the same row. Within the row, the insert reuses an identical live entry, or else takes a free column, or else ORs itself into the live entry with the fewest differing bits. A merged entry is flagged as polluted. The vectors with a single sharer and the vector with all cores sharing never reach the grid. They are given fixed pointer codes just above the grid range, and the read port decodes those codes arithmetically.

Top module: `sharing_pattern_table`

## Requirements
- R1: The row is selected by a vector of NCORE/CLUSTER bits. Bit c is the OR of cores c*CLUSTER to c*CLUSTER+CLUSTER-1. A grid pointer equals row*COLS+column (the defaults are 16 cores, clusters of 4, 16 rows and 2 columns).
- R2: An insert whose vector equals a live entry (count nonzero) of the selected row returns that entry's pointer, adds one to its count, does not alter the stored vector and does not raise ins_merged.
- R3: With no match, the insert takes the lowest free column (count zero), stores the vector, clears its polluted flag, sets its count to one and returns its pointer.
- R4: With no match and no free column, the vector is ORed into the live entry with the smallest Hamming distance, ties going to the lowest column. The response returns that pointer with ins_merged high, the entry's count rises by one and its polluted flag is set.
- R5: A vector with exactly bit i set returns pointer GRID+i, and the all-ones vector returns GRID+NCORE, where GRID=ROWS*COLS. Neither one uses or alters the grid, and ins_merged stays low.
- R6: rd_pattern and rd_polluted show the entry named by rd_ptr one cycle later. Code GRID+i reads as one-hot bit i, code GRID+NCORE reads as all ones, and larger codes read as zero. All reserved codes read with the polluted flag low.
- R7: A release of a grid pointer subtracts one from its count. At zero the column becomes free for later inserts.
- R8: A release of a reserved or out-of-range pointer, or of an entry whose count is already zero, changes nothing.
- R9: A release and an insert in the same cycle both see the state before that cycle. The count of an entry that both touch is left unchanged.
- R10: ins_ack rises exactly one cycle after ins_valid, together with ins_ptr and ins_merged. During reset ins_ack, ins_merged, rd_pattern and rd_polluted are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert request |
| ins_pattern | input | NCORE | Sharer vector to insert |
| rel_valid | input | 1 | Release request |
| rel_ptr | input | PTR_W | Pointer being released |
| rd_ptr | input | PTR_W | Pointer to read |
| ins_ack | output | 1 | Insert response valid |
| ins_ptr | output | PTR_W | Pointer for the inserted vector |
| ins_merged | output | 1 | Insert was folded into an existing entry |
| rd_pattern | output | NCORE | Vector for rd_ptr, one cycle later |
| rd_polluted | output | 1 | Entry read holds merged vectors |

## Verification
A release and an insert can land in the same cycle, and the case that matters is when both name the same entry. This happens when a client drops a pointer and immediately re-inserts the vector that pointer held. The bench drives both in one cycle against an entry whose count is one. It then sends a further insert to the same full row, which must be merged rather than allocated. That result proves the count stayed at one instead of reaching zero. The returned pointer, the merge flag and the vector read back are all compared with values worked out by hand.

// File: rtl/sptab_pkg.sv
package sptab_pkg;
  typedef enum logic [1:0] {
    INS_RESERVED = 2'd0,
    INS_MATCH    = 2'd1,
    INS_ALLOC    = 2'd2,
    INS_MERGE    = 2'd3
  } ins_kind_e;
endpackage

// File: rtl/sptab_row_enc.sv
module sptab_row_enc #(
  parameter int NCORE   = 16,
  parameter int CLUSTER = 4,
  localparam int ROW_W  = NCORE / CLUSTER
) (
  input  logic [NCORE-1:0] pattern,
  output logic [ROW_W-1:0] row
);
  for (genvar c = 0; c < ROW_W; c++) begin : g_cl
    assign row[c] = |pattern[c*CLUSTER +: CLUSTER];
  end
endmodule

// File: rtl/sptab_row_search.sv
module sptab_row_search #(
  parameter int NCORE = 16,
  parameter int COLS  = 2,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic [COLS*NCORE-1:0] row_pat,
  input  logic [COLS-1:0]       row_live,
  input  logic [NCORE-1:0]      in_pat,
  output logic                  hit,
  output logic [COL_W-1:0]      hit_col,
  output logic                  has_free,
  output logic [COL_W-1:0]      free_col,
  output logic [COL_W-1:0]      near_col
);
  int best_d;

  always_comb begin
    hit      = 1'b0;
    hit_col  = '0;
    has_free = 1'b0;
    free_col = '0;
    for (int c = COLS - 1; c >= 0; c--) begin
      if (row_live[c] && row_pat[c*NCORE +: NCORE] == in_pat) begin
        hit     = 1'b1;
        hit_col = COL_W'(c);
      end
      if (!row_live[c]) begin
        has_free = 1'b1;
        free_col = COL_W'(c);
      end
    end
  end

  always_comb begin
    best_d   = NCORE + 1;
    near_col = '0;
    for (int c = 0; c < COLS; c++) begin
      if ($countones(row_pat[c*NCORE +: NCORE] ^ in_pat) < best_d) begin
        best_d   = $countones(row_pat[c*NCORE +: NCORE] ^ in_pat);
        near_col = COL_W'(c);
      end
    end
  end
endmodule

// File: rtl/sptab_reserved.sv
module sptab_reserved #(
  parameter int NCORE = 16,
  parameter int GRID  = 32,
  parameter int PTR_W = 6
) (
  input  logic [NCORE-1:0] in_pat,
  output logic             res_hit,
  output logic [PTR_W-1:0] res_code,
  input  logic [PTR_W-1:0] q_ptr,
  output logic             q_reserved,
  output logic [NCORE-1:0] q_pattern
);
  always_comb begin
    res_hit  = 1'b0;
    res_code = '0;
    if (&in_pat) begin
      res_hit  = 1'b1;
      res_code = PTR_W'(GRID + NCORE);
    end else begin
      for (int i = 0; i < NCORE; i++) begin
        if (in_pat == (NCORE'(1) << i)) begin
          res_hit  = 1'b1;
          res_code = PTR_W'(GRID + i);
        end
      end
    end
  end

  always_comb begin
    q_reserved = (q_ptr >= PTR_W'(GRID));
    q_pattern  = '0;
    if (q_ptr == PTR_W'(GRID + NCORE)) q_pattern = '1;
    for (int i = 0; i < NCORE; i++) begin
      if (q_ptr == PTR_W'(GRID + i)) q_pattern = NCORE'(1) << i;
    end
  end
endmodule

// File: rtl/sharing_pattern_table.sv
module sharing_pattern_table
  import sptab_pkg::*;
#(
  parameter int NCORE   = 16,
  parameter int CLUSTER = 4,
  parameter int COLS    = 2,
  parameter int CNT_W   = 8,
  localparam int ROW_W  = NCORE / CLUSTER,
  localparam int ROWS   = 1 << ROW_W,
  localparam int GRID   = ROWS * COLS,
  localparam int IDX_W  = $clog2(GRID),
  localparam int COL_W  = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int PTR_W  = $clog2(GRID + NCORE + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ins_valid,
  input  logic [NCORE-1:0] ins_pattern,
  input  logic             rel_valid,
  input  logic [PTR_W-1:0] rel_ptr,
  input  logic [PTR_W-1:0] rd_ptr,
  output logic             ins_ack,
  output logic [PTR_W-1:0] ins_ptr,
  output logic             ins_merged,
  output logic [NCORE-1:0] rd_pattern,
  output logic             rd_polluted
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NCORE-1:0] pat_q [GRID];
  logic [CNT_W-1:0] cnt_q [GRID];
  logic [GRID-1:0]  pol_q;

  logic [ROW_W-1:0]      row_sel;
  logic [COLS*NCORE-1:0] row_pat;
  logic [COLS-1:0]       row_live;
  logic                  hit, has_free;
  logic [COL_W-1:0]      hit_col, free_col, near_col, col_sel;
  logic                  res_hit, rd_res;
  logic [PTR_W-1:0]      res_code;
  logic [NCORE-1:0]      rd_res_pat;
  ins_kind_e             kind;
  logic [IDX_W-1:0]      tgt_idx, rel_idx, rd_idx;
  logic [NCORE-1:0]      new_pat;
  logic                  tab_do, rel_ok;

  sptab_row_enc #(.NCORE(NCORE), .CLUSTER(CLUSTER)) u_enc (
    .pattern(ins_pattern), .row(row_sel));

  for (genvar c = 0; c < COLS; c++) begin : g_row
    logic [IDX_W-1:0] e;
    assign e = IDX_W'(int'(row_sel) * COLS + c);
    assign row_pat[c*NCORE +: NCORE] = pat_q[e];
    assign row_live[c] = (cnt_q[e] != '0);
  end

  sptab_row_search #(.NCORE(NCORE), .COLS(COLS)) u_search (
    .row_pat(row_pat), .row_live(row_live), .in_pat(ins_pattern),
    .hit(hit), .hit_col(hit_col), .has_free(has_free),
    .free_col(free_col), .near_col(near_col));

  sptab_reserved #(.NCORE(NCORE), .GRID(GRID), .PTR_W(PTR_W)) u_res (
    .in_pat(ins_pattern), .res_hit(res_hit), .res_code(res_code),
    .q_ptr(rd_ptr), .q_reserved(rd_res), .q_pattern(rd_res_pat));

  always_comb begin
    if (res_hit)       kind = INS_RESERVED;
    else if (hit)      kind = INS_MATCH;
    else if (has_free) kind = INS_ALLOC;
    else               kind = INS_MERGE;
    case (kind)
      INS_MATCH: col_sel = hit_col;
      INS_ALLOC: col_sel = free_col;
      default:   col_sel = near_col;
    endcase
    tgt_idx = IDX_W'(int'(row_sel) * COLS + int'(col_sel));
    new_pat = (kind == INS_ALLOC) ? ins_pattern : (pat_q[tgt_idx] | ins_pattern);
    tab_do  = ins_valid && (kind != INS_RESERVED);
    rel_idx = rel_ptr[IDX_W-1:0];
    rel_ok  = rel_valid && (rel_ptr < PTR_W'(GRID)) && (cnt_q[rel_idx] != '0);
    rd_idx  = rd_ptr[IDX_W-1:0];
  end

  // reference counts and pollution flags
  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q <= '0;
      for (int e = 0; e < GRID; e++) cnt_q[e] <= '0;
    end else begin
      for (int e = 0; e < GRID; e++) begin
        if (tab_do && tgt_idx == IDX_W'(e) && !(rel_ok && rel_idx == IDX_W'(e))) begin
          if (cnt_q[e] != CNT_MAX) cnt_q[e] <= cnt_q[e] + 1'b1;
        end else if (rel_ok && rel_idx == IDX_W'(e) && !(tab_do && tgt_idx == IDX_W'(e))) begin
          cnt_q[e] <= cnt_q[e] - 1'b1;
        end
      end
      if (tab_do && kind == INS_ALLOC) pol_q[tgt_idx] <= 1'b0;
      if (tab_do && kind == INS_MERGE) pol_q[tgt_idx] <= 1'b1;
    end
  end

  // pattern storage: single write port, no reset
  always_ff @(posedge clk) begin
    if (tab_do && (kind == INS_ALLOC || kind == INS_MERGE))
      pat_q[tgt_idx] <= new_pat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ins_ack     <= 1'b0;
      ins_ptr     <= '0;
      ins_merged  <= 1'b0;
      rd_pattern  <= '0;
      rd_polluted <= 1'b0;
    end else begin
      ins_ack    <= ins_valid;
      ins_merged <= tab_do && (kind == INS_MERGE);
      if (ins_valid) ins_ptr <= res_hit ? res_code : PTR_W'(tgt_idx);
      if (rd_res) begin
        rd_pattern  <= rd_res_pat;
        rd_polluted <= 1'b0;
      end else begin
        rd_pattern  <= pat_q[rd_idx];
        rd_polluted <= pol_q[rd_idx];
      end
    end
  end
endmodule

// File: rtl/sptab_chk.sv
module sptab_chk #(
  parameter int NCORE = 16,
  parameter int GRID  = 32,
  parameter int PTR_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             ins_valid,
  input logic [NCORE-1:0] ins_pattern,
  input logic [PTR_W-1:0] rd_ptr,
  input logic             ins_ack,
  input logic [PTR_W-1:0] ins_ptr,
  input logic             ins_merged,
  input logic [NCORE-1:0] rd_pattern
);
  // R10
  ack_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    ins_valid |=> ins_ack);
  // R10
  no_spurious_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !ins_valid |=> !ins_ack);
  // R5
  all_ones_code_chk: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && (&ins_pattern)) |=> (ins_ptr == PTR_W'(GRID + NCORE) && !ins_merged));
  // R5
  single_sharer_code_chk: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && $countones(ins_pattern) == 1) |=> (ins_ptr >= PTR_W'(GRID) && !ins_merged));
  // R4
  merge_in_grid_chk: assert property (@(posedge clk) disable iff (rst)
    (ins_ack && ins_merged) |-> (ins_ptr < PTR_W'(GRID)));
  // R6
  read_all_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_ptr == PTR_W'(GRID + NCORE)) |=> (&rd_pattern));
  // R6
  read_out_of_range_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_ptr > PTR_W'(GRID + NCORE)) |=> (rd_pattern == '0));
endmodule

bind sharing_pattern_table sptab_chk #(.NCORE(NCORE), .GRID(GRID), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_pattern(ins_pattern),
  .rd_ptr(rd_ptr), .ins_ack(ins_ack), .ins_ptr(ins_ptr),
  .ins_merged(ins_merged), .rd_pattern(rd_pattern));

// File: tb/tb_sharing_pattern_table.sv
module tb_sharing_pattern_table;
  localparam int NCORE = 16;
  localparam int PTR_W = 6;
  localparam int GRID  = 32;

  logic             clk = 1'b0;
  logic             rst;
  logic             ins_valid, rel_valid;
  logic [NCORE-1:0] ins_pattern;
  logic [PTR_W-1:0] rel_ptr, rd_ptr;
  logic             ins_ack, ins_merged, rd_polluted;
  logic [PTR_W-1:0] ins_ptr;
  logic [NCORE-1:0] rd_pattern;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  sharing_pattern_table dut (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_pattern(ins_pattern),
    .rel_valid(rel_valid), .rel_ptr(rel_ptr), .rd_ptr(rd_ptr),
    .ins_ack(ins_ack), .ins_ptr(ins_ptr), .ins_merged(ins_merged),
    .rd_pattern(rd_pattern), .rd_polluted(rd_polluted));

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic insert(input logic [NCORE-1:0] p, input int exp_ptr,
                        input int exp_merged, input string req);
    @(negedge clk);
    ins_valid = 1'b1; ins_pattern = p;
    @(negedge clk);
    ins_valid = 1'b0;
    check({req, " ack"}, int'(ins_ack), 1);
    check({req, " ptr"}, int'(ins_ptr), exp_ptr);
    check({req, " merged"}, int'(ins_merged), exp_merged);
  endtask

  task automatic release_ptr(input int ptr);
    @(negedge clk);
    rel_valid = 1'b1; rel_ptr = PTR_W'(ptr);
    @(negedge clk);
    rel_valid = 1'b0;
  endtask

  task automatic read(input int ptr, input int exp_pat, input int exp_pol, input string req);
    @(negedge clk);
    rd_ptr = PTR_W'(ptr);
    @(negedge clk);
    check({req, " pattern"}, int'(rd_pattern), exp_pat);
    check({req, " polluted"}, int'(rd_polluted), exp_pol);
  endtask

  task automatic t_reset;
    rst = 1'b1; ins_valid = 1'b0; rel_valid = 1'b0;
    ins_pattern = '0; rel_ptr = '0; rd_ptr = '0;
    repeat (4) @(negedge clk);
    check("R10 reset ack", int'(ins_ack), 0);
    check("R10 reset merged", int'(ins_merged), 0);
    check("R10 reset rd_pattern", int'(rd_pattern), 0);
    check("R10 reset rd_polluted", int'(rd_polluted), 0);
    rst = 1'b0;
  endtask

  task automatic t_reserved;
    insert(16'h0010, GRID + 4, 0, "R5 one-hot core 4");
    insert(16'hFFFF, GRID + NCORE, 0, "R5 all ones");
    read(GRID + 3, 16'h0008, 0, "R6 reserved one-hot");
    read(GRID + NCORE, 16'hFFFF, 0, "R6 reserved all ones");
    read(63, 0, 0, "R6 out of range");
  endtask

  task automatic t_alloc_match;
    insert(16'h0003, 2, 0, "R1 R3 alloc row1 col0");
    insert(16'h0003, 2, 0, "R2 exact match");
    insert(16'h0005, 3, 0, "R3 alloc row1 col1");
    read(2, 16'h0003, 0, "R6 stored entry");
  endtask

  task automatic t_merge;
    insert(16'h0009, 2, 1, "R4 tie to lowest column");
    read(2, 16'h000B, 1, "R4 merged value");
    insert(16'h0006, 3, 1, "R4 nearest column");
    read(3, 16'h0007, 1, "R4 merged value col1");
  endtask

  task automatic t_release;
    release_ptr(3);
    release_ptr(3);
    insert(16'h000C, 3, 0, "R7 freed column reused");
    read(3, 16'h000C, 0, "R7 R3 fresh entry");
  endtask

  task automatic t_ignored;
    insert(16'h0030, 4, 0, "R1 row2 alloc");
    release_ptr(GRID + 4);
    insert(16'h0050, 5, 0, "R8 reserved release ignored");
    release_ptr(4);
    release_ptr(4);
    insert(16'h0070, 4, 0, "R8 zero-count release ignored");
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    ins_valid = 1'b1; ins_pattern = 16'h000C;
    rel_valid = 1'b1; rel_ptr = PTR_W'(3);
    @(negedge clk);
    ins_valid = 1'b0; rel_valid = 1'b0;
    check("R9 same-cycle ptr", int'(ins_ptr), 3);
    check("R9 same-cycle merged", int'(ins_merged), 0);
    insert(16'h000D, 3, 1, "R9 count held, row full");
    read(3, 16'h000D, 1, "R9 merged readback");
  endtask

  initial begin
    #(5ns * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_reserved();
    t_alloc_match();
    t_merge();
    t_release();
    t_ignored();
    t_same_cycle();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule